// File: doc/BRIEF.md
# Carry-Lookahead Arithmetic and Logic Unit

A purely combinational 16-bit unit that adds, subtracts and applies bitwise logic to two two's-complement operands. Addition and subtraction share a single adder. For subtraction the second operand is inverted and a carry of one is injected at the least significant bit. The adder finds its carries with lookahead rather than a ripple chain. Four 4-bit groups each compute their internal carries from the bit-level generate and propagate terms. Each group also exports a group generate and a group propagate. A second lookahead level turns these into the carries at bits 4, 8 and 12, and a paired tree of group terms yields the final carry out of bit 15.

Each operation produces a result, a carry out, a signed overflow flag and a zero flag. The overflow rule depends on the operation. Logical operations clear both arithmetic flags. The unit sits in a datapath where the operands and the operation select settle within a cycle, and the outputs are read in that same cycle.

Top module: `cla_alu16`

## Requirements
- R1: With op_sel = 3'b000, result equals (opnd_a + opnd_b) mod 2^16, and carry_out equals bit 16 of the unsigned 17-bit sum.
- R2: With op_sel = 3'b001, result equals (opnd_a - opnd_b) mod 2^16, and carry_out is 1 exactly when opnd_a >= opnd_b as unsigned numbers. This is the carry of opnd_a + ~opnd_b + 1.
- R3: For op_sel = 3'b000, ovf is 1 exactly when both operands have equal sign bits (bit 15) and the result's sign bit differs from them.
- R4: For op_sel = 3'b001, ovf is 1 exactly when the operands' sign bits differ and the result's sign bit differs from that of opnd_a. Equal-signed operands never overflow.
- R5: op_sel 3'b010 gives AND, 3'b011 gives OR, 3'b100 gives XOR and 3'b101 gives NOR of the two operands, bit by bit.
- R6: For every op_sel other than 3'b000 and 3'b001, carry_out and ovf are 0.
- R7: zero is 1 exactly when all 16 result bits are 0, for every operation.
- R8: The unused codes 3'b110 and 3'b111 give a result of 0, so zero is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_a | input | 16 | First operand, two's complement |
| opnd_b | input | 16 | Second operand, two's complement |
| op_sel | input | 3 | Operation code (see R1, R2, R5, R8) |
| result | output | 16 | Operation result |
| carry_out | output | 1 | Carry out of bit 15 (arithmetic only) |
| ovf | output | 1 | Signed overflow flag |
| zero | output | 1 | Result is all zeros |

## Verification
The bench targets the carry paths that cross group boundaries.

- 0xFFFF + 1 must carry through all four groups to a zero result with carry_out set. A wrong second-level term or a wrong group-propagate term would leave nonzero upper nibbles or drop the carry.
- 0x7FFF + 1 and 0x8000 - 1 are the two overflow edges. A design that applied the addition rule to subtraction would report no overflow on the second.
- 0x7FFF - 0xFFFF must overflow with carry_out clear. A missing inverter or a missing injected carry on the subtract path would produce an off-by-one difference.
- Random operands for every operation are compared against an integer reference. This catches a wrong carry at any group boundary.

// File: rtl/cla_alu16.sv
`timescale 1ns/1ps
module cla_alu16 (
  input  logic [15:0] opnd_a,
  input  logic [15:0] opnd_b,
  input  logic [2:0]  op_sel,
  output logic [15:0] result,
  output logic        carry_out,
  output logic        ovf,
  output logic        zero
);
  localparam int W      = 16;
  localparam int GW     = 4;
  localparam int NGRP   = W / GW;
  localparam logic [2:0] OP_ADD = 3'b000;
  localparam logic [2:0] OP_SUB = 3'b001;
  localparam logic [2:0] OP_AND = 3'b010;
  localparam logic [2:0] OP_OR  = 3'b011;
  localparam logic [2:0] OP_XOR = 3'b100;
  localparam logic [2:0] OP_NOR = 3'b101;

  logic          do_sub;
  logic [W-1:0]  b_eff, gen, prop, sum;
  logic [W:0]    cy;
  logic [NGRP-1:0] grp_g, grp_p;
  logic          g_lo, p_lo, g_hi, p_hi, g_all, p_all;

  assign do_sub = (op_sel == OP_SUB);
  assign b_eff  = opnd_b ^ {W{do_sub}};
  assign gen    = opnd_a & b_eff;
  assign prop   = opnd_a ^ b_eff;

  for (genvar gi = 0; gi < NGRP; gi++) begin : g_grp
    logic [GW-1:0] gg, pp;
    logic          cin;
    assign gg  = gen[gi*GW +: GW];
    assign pp  = prop[gi*GW +: GW];
    assign cin = cy[gi*GW];
    assign cy[gi*GW+1] = gg[0] | (pp[0] & cin);
    assign cy[gi*GW+2] = gg[1] | (pp[1] & gg[0]) | (pp[1] & pp[0] & cin);
    assign cy[gi*GW+3] = gg[2] | (pp[2] & gg[1]) | (pp[2] & pp[1] & gg[0])
                       | (pp[2] & pp[1] & pp[0] & cin);
    assign grp_g[gi] = gg[3] | (pp[3] & gg[2]) | (pp[3] & pp[2] & gg[1])
                     | (pp[3] & pp[2] & pp[1] & gg[0]);
    assign grp_p[gi] = &pp;
  end

  assign cy[0]  = do_sub;
  assign cy[4]  = grp_g[0] | (grp_p[0] & cy[0]);
  assign cy[8]  = grp_g[1] | (grp_p[1] & grp_g[0]) | (grp_p[1] & grp_p[0] & cy[0]);
  assign cy[12] = grp_g[2] | (grp_p[2] & grp_g[1]) | (grp_p[2] & grp_p[1] & grp_g[0])
                | (grp_p[2] & grp_p[1] & grp_p[0] & cy[0]);

  assign g_lo   = grp_g[1] | (grp_p[1] & grp_g[0]);
  assign p_lo   = grp_p[1] & grp_p[0];
  assign g_hi   = grp_g[3] | (grp_p[3] & grp_g[2]);
  assign p_hi   = grp_p[3] & grp_p[2];
  assign g_all  = g_hi | (p_hi & g_lo);
  assign p_all  = p_hi & p_lo;
  assign cy[16] = g_all | (p_all & cy[0]);

  assign sum = prop ^ cy[W-1:0];

  always_comb begin
    result    = '0;
    carry_out = 1'b0;
    ovf       = 1'b0;
    case (op_sel)
      OP_ADD: begin
        result    = sum;
        carry_out = cy[W];
        ovf       = (opnd_a[W-1] == opnd_b[W-1]) && (sum[W-1] != opnd_a[W-1]);
      end
      OP_SUB: begin
        result    = sum;
        carry_out = cy[W];
        ovf       = (opnd_a[W-1] != opnd_b[W-1]) && (sum[W-1] != opnd_a[W-1]);
      end
      OP_AND:  result = opnd_a & opnd_b;
      OP_OR:   result = opnd_a | opnd_b;
      OP_XOR:  result = opnd_a ^ opnd_b;
      OP_NOR:  result = ~(opnd_a | opnd_b);
      default: result = '0;
    endcase
  end

  assign zero = ~|result;
endmodule

module cla_alu16_chk (
  input logic [15:0] opnd_a,
  input logic [15:0] opnd_b,
  input logic [2:0]  op_sel,
  input logic [15:0] result,
  input logic        carry_out,
  input logic        ovf,
  input logic        zero
);
  logic [16:0] ref_sum;
  int          sa, sb, sr;

  always_comb begin
    ref_sum = '0;
    sa = 0; sb = 0; sr = 0;
    if (!$isunknown({opnd_a, opnd_b, op_sel, result, carry_out, ovf, zero})) begin
      sa = int'($signed(opnd_a));
      sb = int'($signed(opnd_b));
      if (op_sel == 3'b000) begin
        ref_sum = {1'b0, opnd_a} + {1'b0, opnd_b};
        sr = sa + sb;
        AST_ADD_SUM: assert ({carry_out, result} == ref_sum); // R1
        AST_ADD_OVF: assert (ovf == (sr > 32767 || sr < -32768)); // R3
      end
      if (op_sel == 3'b001) begin
        sr = sa - sb;
        AST_SUB_DIFF: assert (result == 16'(opnd_a - opnd_b) && carry_out == (opnd_a >= opnd_b)); // R2
        AST_SUB_OVF: assert (ovf == (sr > 32767 || sr < -32768)); // R4
        AST_SUB_ZERO: assert (zero == (opnd_a == opnd_b)); // R7
      end
      if (op_sel[2:1] != 2'b00)
        AST_LOGIC_FLAGS: assert (!carry_out && !ovf); // R6
      if (op_sel[2:1] == 2'b11)
        AST_UNUSED_OP: assert (result == 16'h0000 && zero); // R8
    end
  end
endmodule

bind cla_alu16 cla_alu16_chk u_chk (
  .opnd_a(opnd_a), .opnd_b(opnd_b), .op_sel(op_sel),
  .result(result), .carry_out(carry_out), .ovf(ovf), .zero(zero)
);

// File: tb/cla_alu16_test.sv
`timescale 1ns/1ps
module cla_alu16_test;
  logic        clk = 1'b0;
  logic [15:0] opnd_a, opnd_b, result;
  logic [2:0]  op_sel;
  logic        carry_out, ovf, zero;
  int          n_cmp = 0, n_bad = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  cla_alu16 uut (
    .opnd_a(opnd_a), .opnd_b(opnd_b), .op_sel(op_sel),
    .result(result), .carry_out(carry_out), .ovf(ovf), .zero(zero)
  );

  // {op, a, b, result, carry, ovf, zero}
  localparam int NV = 15;
  localparam logic [53:0] VEC [NV] = '{
    {3'b000, 16'h7FFF, 16'h0001, 16'h8000, 1'b0, 1'b1, 1'b0},
    {3'b001, 16'h8000, 16'h0001, 16'h7FFF, 1'b1, 1'b1, 1'b0},
    {3'b000, 16'hFFFF, 16'h0001, 16'h0000, 1'b1, 1'b0, 1'b1},
    {3'b001, 16'h1234, 16'h1234, 16'h0000, 1'b1, 1'b0, 1'b1},
    {3'b001, 16'h0001, 16'h0002, 16'hFFFF, 1'b0, 1'b0, 1'b0},
    {3'b000, 16'h8000, 16'h8000, 16'h0000, 1'b1, 1'b1, 1'b1},
    {3'b001, 16'h7FFF, 16'hFFFF, 16'h8000, 1'b0, 1'b1, 1'b0},
    {3'b010, 16'hF0F0, 16'h3C3C, 16'h3030, 1'b0, 1'b0, 1'b0},
    {3'b011, 16'hF0F0, 16'h0F00, 16'hFFF0, 1'b0, 1'b0, 1'b0},
    {3'b100, 16'hAAAA, 16'hAAAA, 16'h0000, 1'b0, 1'b0, 1'b1},
    {3'b101, 16'h00FF, 16'h0F00, 16'hF000, 1'b0, 1'b0, 1'b0},
    {3'b101, 16'hFFFF, 16'h0000, 16'h0000, 1'b0, 1'b0, 1'b1},
    {3'b110, 16'h1234, 16'h5678, 16'h0000, 1'b0, 1'b0, 1'b1},
    {3'b000, 16'h1234, 16'h4321, 16'h5555, 1'b0, 1'b0, 1'b0},
    {3'b000, 16'hFFFF, 16'hFFFF, 16'hFFFE, 1'b1, 1'b0, 1'b0}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s op=%b a=%h b=%h actual=%h expected=%h", tag, op_sel, opnd_a, opnd_b, act, exp);
    end
  endtask

  task automatic apply(input logic [2:0] op, input logic [15:0] a, input logic [15:0] b);
    @(posedge clk);
    op_sel = op; opnd_a = a; opnd_b = b;
    @(negedge clk);
  endtask

  task automatic check_ref;
    int sa, sb, sr;
    logic [16:0] s17;
    logic [15:0] er;
    logic ec, eo;
    sa = int'($signed(opnd_a)); sb = int'($signed(opnd_b));
    ec = 1'b0; eo = 1'b0; sr = 0; s17 = '0;
    case (op_sel)
      3'b000: begin s17 = {1'b0, opnd_a} + {1'b0, opnd_b}; er = s17[15:0]; ec = s17[16]; sr = sa + sb; end
      3'b001: begin er = opnd_a - opnd_b; ec = (opnd_a >= opnd_b); sr = sa - sb; end
      3'b010: er = opnd_a & opnd_b;
      3'b011: er = opnd_a | opnd_b;
      3'b100: er = opnd_a ^ opnd_b;
      3'b101: er = ~(opnd_a | opnd_b);
      default: er = 16'h0000;
    endcase
    if (op_sel[2:1] == 2'b00) eo = (sr > 32767) || (sr < -32768);
    check(op_sel == 3'b001 ? "R2 result" : (op_sel == 3'b000 ? "R1 result" : "R5 result"), 32'(result), 32'(er));
    check(op_sel[2:1] == 2'b00 ? "R1/R2 carry" : "R6 carry", 32'(carry_out), 32'(ec));
    check(op_sel == 3'b001 ? "R4 ovf" : (op_sel == 3'b000 ? "R3 ovf" : "R6 ovf"), 32'(ovf), 32'(eo));
    check("R7 zero", 32'(zero), 32'(er == 16'h0000));
  endtask

  initial begin
    op_sel = 3'b000; opnd_a = '0; opnd_b = '0;
    @(negedge clk);
    check("R7 initial zero", 32'(zero), 32'd1);
    check("R1 initial result", 32'(result), 32'd0);

    for (int i = 0; i < NV; i++) begin
      apply(VEC[i][53:51], VEC[i][50:35], VEC[i][34:19]);
      check("R1/R2/R5/R8 table result", 32'(result), 32'(VEC[i][18:3]));
      check("R1/R2/R6 table carry", 32'(carry_out), 32'(VEC[i][2]));
      check("R3/R4/R6 table ovf", 32'(ovf), 32'(VEC[i][1]));
      check("R7 table zero", 32'(zero), 32'(VEC[i][0]));
    end

    // R8: the other unused code
    apply(3'b111, 16'hFFFF, 16'hFFFF);
    check("R8 unused result", 32'(result), 32'd0);
    check("R8 unused zero", 32'(zero), 32'd1);
    check("R6 unused carry", 32'(carry_out), 32'd0);

    // R6: logic op on operands that would carry and overflow if added
    apply(3'b011, 16'h8000, 16'h8000);
    check("R6 or carry", 32'(carry_out), 32'd0);
    check("R6 or ovf", 32'(ovf), 32'd0);

    for (int i = 0; i < 1500; i++) begin
      apply(3'(i % 8), 16'($urandom), 16'($urandom));
      check_ref();
    end
    for (int i = 0; i < 64; i++) begin
      apply(3'(i % 2), 16'h8000 ^ 16'(i * 16'h1111), 16'h7FFF ^ 16'(i * 16'h0F0F));
      check_ref();
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule